// File: doc/BRIEF.md
# Tagged Inter-Thread FIFO Cell

This block is a single queue used by several hardware threads to pass data words to each other. Every access carries a two-bit view code that picks how the queue is reached. The raw view reads or patches entries without changing the order. The tag view reads or loads the status word. Two queue views push on write and pop on read; one of them makes a requester wait, the other only polls. The empty and full flags are ordinary status bits. Software can load them, and they alone decide whether a waiting-view access is held off.

A requester that is held off gets a response marked blocked, and its identifier is recorded in a waiter mask. The next queue-view access that is not held off releases every recorded waiter at once. For one cycle the wake vector then carries the released mask, and the mask is cleared. The thread scheduler re-issues the access of each woken thread. Halting and resuming threads is outside this block.

Top module: `itc_fifo_cell`

## Requirements
- R1: Every request (`reqValid` high) gives exactly one response in the next cycle, and no response appears without a request. View codes on `reqView`: 0 raw, 1 tag, 2 waiting queue view, 3 polling queue view.
- R2: After reset the tag word reads with empty=1, full=0, user bit T=0, queue mode=1, count=0 and log2(DEPTH) in the depth field. Tag layout: empty at bit 0, full at bit 1, T at bit 16, mode at bit 17, count from bit 18, log2 depth from bit 28.
- R3: A tag-view write loads T, empty and full from data bits 16, 0 and 1. If the new empty bit is 1, the count becomes zero.
- R4: A raw-view read returns the head entry and does not pop it.
- R5: A raw-view write replaces the most recently pushed entry when the count is nonzero. When the count is zero it has no effect.
- R6: A queue-view read clears full. A waiting-view read with empty set is blocked: response data zero, requester bit added to the waiter mask, nothing else changed.
- R7: A queue-view read that is not blocked returns and pops the head when the count is nonzero and returns zero otherwise. Empty is set when the count is zero afterwards.
- R8: A queue-view write clears empty. A waiting-view write with full set is blocked and pushes nothing.
- R9: A queue-view write that is not blocked pushes when count < DEPTH and is dropped otherwise. Full is set when the count equals DEPTH afterwards.
- R10: A queue-view access that is not blocked puts the waiter mask on `wakeVec` for exactly one cycle, along with its response, and clears the mask.
- R11: A polling-view access is never blocked.
- R12: Entries leave in push order, and the head and tail positions wrap modulo DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqView | input | 2 | View code |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | DATA_W | Write data |
| reqId | input | $clog2(NUM_REQ) | Requester identifier |
| rspValid | output | 1 | Response strobe |
| rspData | output | DATA_W | Read data |
| rspBlocked | output | 1 | Access was held off |
| wakeVec | output | NUM_REQ | One-cycle release of recorded waiters |

## Verification
The assertions assume that the requester identifier is below NUM_REQ and that the view code is stable and known whenever `reqValid` is high. They also assume that at most one request arrives per cycle, since the port has no backpressure. The stimulus always drives legal identifiers and all four view codes, with one request or an idle slot per cycle. It also loads empty and full through the tag view to values that disagree with the count. These states are legal here, so the assertions about count bounds and the wake pulse must hold in them as well.

// File: rtl/itc_cell_pkg.sv
package itc_cell_pkg;

  typedef enum logic [1:0] {
    VIEW_RAW  = 2'd0,
    VIEW_TAG  = 2'd1,
    VIEW_WAIT = 2'd2,
    VIEW_POLL = 2'd3
  } view_e;

  localparam int TAG_E_BIT     = 0;
  localparam int TAG_F_BIT     = 1;
  localparam int TAG_T_BIT     = 16;
  localparam int TAG_MODE_BIT  = 17;
  localparam int TAG_CNT_LSB   = 18;
  localparam int TAG_DEPTH_LSB = 28;
  localparam int TAG_DEPTH_W   = 4;

  // control -> datapath strobes
  typedef struct packed {
    logic push;   // write at tail, advance nothing (count grows in control)
    logic patch;  // overwrite newest entry
    logic pop;    // advance head
  } cell_stb_t;

endpackage

// File: rtl/itc_cell_store.sv
module itc_cell_store
  import itc_cell_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  cell_stb_t                stb,
  input  logic [$clog2(DEPTH)-1:0] cntLow,
  input  logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        headData
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  headIdx;
  logic [PTR_W-1:0]  tailIdx;
  logic [PTR_W-1:0]  lastIdx;

  assign tailIdx  = headIdx + cntLow;
  assign lastIdx  = tailIdx - PTR_W'(1);
  assign headData = mem[headIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headIdx <= '0;
    end else if (stb.pop) begin
      headIdx <= headIdx + PTR_W'(1);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        mem[g] <= '0;
      end else if (stb.push && tailIdx == PTR_W'(g)) begin
        mem[g] <= wrData;
      end else if (stb.patch && lastIdx == PTR_W'(g)) begin
        mem[g] <= wrData;
      end
    end
  end

  // R9
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({stb.push, stb.patch, stb.pop}) <= 1);

  // R12
  pop_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.pop |=> $stable(headIdx));

endmodule

// File: rtl/itc_cell_ctrl.sv
module itc_cell_ctrl
  import itc_cell_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 8,
  parameter int NUM_REQ = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic [1:0]                 reqView,
  input  logic                       reqWrite,
  input  logic [2:0]                 ctlBits,  // {T, F, E} from write data
  input  logic [$clog2(NUM_REQ)-1:0] reqId,
  input  logic [DATA_W-1:0]          headData,
  output cell_stb_t                  stb,
  output logic [$clog2(DEPTH)-1:0]   cntLow,
  output logic                       rspValid,
  output logic [DATA_W-1:0]          rspData,
  output logic                       rspBlocked,
  output logic [NUM_REQ-1:0]         wakeVec
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  view_e view;
  assign view = view_e'(reqView);

  logic              tagE, tagF, tagT;
  logic [CNT_W-1:0]  count;
  logic [NUM_REQ-1:0] waitMask;

  logic              nE, nF, nT;
  logic [CNT_W-1:0]  nCnt;
  logic [NUM_REQ-1:0] nMask, nWake;
  logic              nBlk;
  logic [DATA_W-1:0] nData;
  logic [DATA_W-1:0] tagWord;
  logic              waitView;

  assign cntLow   = count[PTR_W-1:0];
  assign waitView = (view == VIEW_WAIT);

  always_comb begin
    tagWord                                 = '0;
    tagWord[TAG_E_BIT]                      = tagE;
    tagWord[TAG_F_BIT]                      = tagF;
    tagWord[TAG_T_BIT]                      = tagT;
    tagWord[TAG_MODE_BIT]                   = 1'b1;
    tagWord[TAG_CNT_LSB +: CNT_W]           = count;
    tagWord[TAG_DEPTH_LSB +: TAG_DEPTH_W]   = TAG_DEPTH_W'(PTR_W);
  end

  always_comb begin
    nE    = tagE;
    nF    = tagF;
    nT    = tagT;
    nCnt  = count;
    nMask = waitMask;
    nWake = '0;
    nBlk  = 1'b0;
    nData = '0;
    stb   = '0;
    if (reqValid) begin
      unique case (view)
        VIEW_RAW: begin
          if (reqWrite) begin
            stb.patch = (count != '0);
          end else begin
            nData = headData;
          end
        end
        VIEW_TAG: begin
          if (reqWrite) begin
            nT = ctlBits[2];
            nF = ctlBits[1];
            nE = ctlBits[0];
            if (ctlBits[0]) nCnt = '0;
          end else begin
            nData = tagWord;
          end
        end
        default: begin
          if (!reqWrite) begin
            nF = 1'b0;
            if (waitView && tagE) begin
              nBlk  = 1'b1;
              nMask = waitMask | (NUM_REQ'(1) << reqId);
            end else begin
              nWake = waitMask;
              nMask = '0;
              if (count != '0) begin
                nData   = headData;
                stb.pop = 1'b1;
                nCnt    = count - CNT_W'(1);
              end
              if (nCnt == '0) nE = 1'b1;
            end
          end else begin
            nE = 1'b0;
            if (waitView && tagF) begin
              nBlk  = 1'b1;
              nMask = waitMask | (NUM_REQ'(1) << reqId);
            end else begin
              nWake = waitMask;
              nMask = '0;
              if (count < CNT_W'(DEPTH)) begin
                stb.push = 1'b1;
                nCnt     = count + CNT_W'(1);
              end
              if (nCnt == CNT_W'(DEPTH)) nF = 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagE       <= 1'b1;
      tagF       <= 1'b0;
      tagT       <= 1'b0;
      count      <= '0;
      waitMask   <= '0;
      rspValid   <= 1'b0;
      rspData    <= '0;
      rspBlocked <= 1'b0;
      wakeVec    <= '0;
    end else begin
      tagE       <= nE;
      tagF       <= nF;
      tagT       <= nT;
      count      <= nCnt;
      waitMask   <= nMask;
      rspValid   <= reqValid;
      rspData    <= nData;
      rspBlocked <= nBlk;
      wakeVec    <= nWake;
    end
  end

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R10
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wakeVec != '0) |=> (wakeVec == '0));

  // R6
  blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspBlocked |-> (rspData == '0 && wakeVec == '0));

  // R8
  full_block_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && view == VIEW_WAIT && reqWrite && tagF) |=> $stable(count));

  // R11
  poll_never_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && view == VIEW_POLL) |=> !rspBlocked);

  // R1
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R1
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

endmodule

// File: rtl/itc_fifo_cell.sv
module itc_fifo_cell
  import itc_cell_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 8,
  parameter int NUM_REQ = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic [1:0]                 reqView,
  input  logic                       reqWrite,
  input  logic [DATA_W-1:0]          reqWdata,
  input  logic [$clog2(NUM_REQ)-1:0] reqId,
  output logic                       rspValid,
  output logic [DATA_W-1:0]          rspData,
  output logic                       rspBlocked,
  output logic [NUM_REQ-1:0]         wakeVec
);
  localparam int PTR_W = $clog2(DEPTH);

  cell_stb_t         stb;
  logic [PTR_W-1:0]  cntLow;
  logic [DATA_W-1:0] headData;

  itc_cell_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .NUM_REQ(NUM_REQ)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqView    (reqView),
    .reqWrite   (reqWrite),
    .ctlBits    ({reqWdata[TAG_T_BIT], reqWdata[TAG_F_BIT], reqWdata[TAG_E_BIT]}),
    .reqId      (reqId),
    .headData   (headData),
    .stb        (stb),
    .cntLow     (cntLow),
    .rspValid   (rspValid),
    .rspData    (rspData),
    .rspBlocked (rspBlocked),
    .wakeVec    (wakeVec)
  );

  itc_cell_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .cntLow   (cntLow),
    .wrData   (reqWdata),
    .headData (headData)
  );

endmodule

// File: tb/itc_fifo_cell_tb.sv
module itc_fifo_cell_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 32;
  localparam int DEPTH      = 8;
  localparam int NUM_REQ    = 4;
  localparam int ID_W       = $clog2(NUM_REQ);

  localparam logic [1:0] V_RAW = 2'd0, V_TAG = 2'd1, V_WAIT = 2'd2, V_POLL = 2'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqView = '0;
  logic reqWrite = 1'b0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic [ID_W-1:0] reqId = '0;
  logic rspValid;
  logic [DATA_W-1:0] rspData;
  logic rspBlocked;
  logic [NUM_REQ-1:0] wakeVec;

  always #(CLK_PERIOD/2) clk = ~clk;

  itc_fifo_cell #(.DATA_W(DATA_W), .DEPTH(DEPTH), .NUM_REQ(NUM_REQ)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqView(reqView),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .reqId(reqId),
    .rspValid(rspValid), .rspData(rspData), .rspBlocked(rspBlocked),
    .wakeVec(wakeVec)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // scoreboard queues
  logic [DATA_W-1:0]  qData[$];
  bit                 qBlk[$];
  logic [NUM_REQ-1:0] qWake[$];
  string              qTag[$];

  // reference model state
  logic [DATA_W-1:0] mMem[DEPTH];
  int mHead, mCnt;
  bit mE, mF, mT;
  logic [NUM_REQ-1:0] mMask;

  function automatic logic [DATA_W-1:0] modelTag();
    logic [DATA_W-1:0] w = '0;
    w[0] = mE; w[1] = mF; w[16] = mT; w[17] = 1'b1;
    w = w | (DATA_W'(mCnt) << 18) | (DATA_W'($clog2(DEPTH)) << 28);
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] ctlWord(bit t, bit f, bit e);
    return (DATA_W'(t) << 16) | (DATA_W'(f) << 1) | DATA_W'(e);
  endfunction

  task automatic check(bit ok, string tag, string act, string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %s expected %s", tag, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && rspValid && !done) begin
      if (qData.size() == 0) begin
        check(1'b0, "R1 response without request", "rsp", "none");
      end else begin
        logic [DATA_W-1:0] eD;
        bit eB;
        logic [NUM_REQ-1:0] eW;
        string t;
        eD = qData.pop_front(); eB = qBlk.pop_front();
        eW = qWake.pop_front(); t = qTag.pop_front();
        check(rspData === eD && rspBlocked === eB && wakeVec === eW, t,
              $sformatf("d=%h b=%0d w=%b", rspData, rspBlocked, wakeVec),
              $sformatf("d=%h b=%0d w=%b", eD, eB, eW));
      end
    end
  end

  // driver with model
  task automatic send(logic [1:0] v, bit wr, logic [DATA_W-1:0] d, int id, string tag);
    logic [DATA_W-1:0] eD = '0;
    bit eB = 0;
    logic [NUM_REQ-1:0] eW = '0;
    bit wt;
    @(negedge clk);
    reqValid = 1'b1; reqView = v; reqWrite = wr; reqWdata = d; reqId = ID_W'(id);
    wt = (v == V_WAIT);
    case (v)
      V_RAW: begin
        if (wr) begin
          if (mCnt > 0) mMem[(mHead + mCnt - 1) % DEPTH] = d;
        end else eD = mMem[mHead];
      end
      V_TAG: begin
        if (wr) begin
          mT = d[16]; mF = d[1]; mE = d[0];
          if (mE) mCnt = 0;
        end else eD = modelTag();
      end
      default: begin
        if (!wr) begin
          mF = 0;
          if (wt && mE) begin
            eB = 1; mMask = mMask | (NUM_REQ'(1) << id);
          end else begin
            eW = mMask; mMask = '0;
            if (mCnt > 0) begin
              eD = mMem[mHead]; mHead = (mHead + 1) % DEPTH; mCnt--;
            end
            if (mCnt == 0) mE = 1;
          end
        end else begin
          mE = 0;
          if (wt && mF) begin
            eB = 1; mMask = mMask | (NUM_REQ'(1) << id);
          end else begin
            eW = mMask; mMask = '0;
            if (mCnt < DEPTH) begin
              mMem[(mHead + mCnt) % DEPTH] = d; mCnt++;
            end
            if (mCnt == DEPTH) mF = 1;
          end
        end
      end
    endcase
    qData.push_back(eD); qBlk.push_back(eB); qWake.push_back(eW); qTag.push_back(tag);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      reqValid = 1'b0;
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mMem[i] = '0;
    mHead = 0; mCnt = 0; mE = 1; mF = 0; mT = 0; mMask = '0;
    repeat (3) @(negedge clk);
    check(rspValid === 1'b0 && wakeVec === '0, "R1 quiet in reset",
          $sformatf("v=%b w=%b", rspValid, wakeVec), "v=0 w=0");
    rstN = 1'b1;

    send(V_TAG, 0, 0, 0, "R2 reset tag word");
    send(V_POLL, 0, 0, 0, "R11 R7 poll read empty returns zero");
    send(V_WAIT, 0, 0, 1, "R6 wait read on empty blocks id1");
    send(V_WAIT, 0, 0, 2, "R6 wait read on empty blocks id2");
    send(V_TAG, 0, 0, 0, "R6 tag unchanged by blocked reads");
    send(V_POLL, 1, 32'hA1, 0, "R10 push releases waiters");
    send(V_RAW, 0, 0, 0, "R4 raw read head");
    send(V_RAW, 0, 0, 0, "R4 raw read does not pop");
    send(V_RAW, 1, 32'hB1, 0, "R5 raw write patches newest");
    send(V_POLL, 0, 0, 3, "R7 pop patched entry");
    send(V_RAW, 1, 32'hC0, 0, "R5 raw write ignored when empty");
    send(V_TAG, 0, 0, 0, "R5 R7 count zero empty set");
    send(V_RAW, 0, 0, 0, "R5 head entry untouched");

    for (int i = 0; i < DEPTH; i++) send(V_WAIT, 1, 32'h100 + i, i % NUM_REQ, "R9 fill");
    send(V_TAG, 0, 0, 0, "R9 full set at depth");
    send(V_WAIT, 1, 32'hDEAD, 3, "R8 wait write on full blocks");
    send(V_POLL, 1, 32'hBEEF, 0, "R9 R10 poll write when full dropped, wakes");
    send(V_TAG, 0, 0, 0, "R8 empty cleared by write");
    for (int i = 0; i < DEPTH; i++) send(V_WAIT, 0, 0, 1, "R12 order with wrap");
    send(V_TAG, 0, 0, 0, "R7 empty after drain");

    send(V_TAG, 1, ctlWord(1, 0, 0), 0, "R3 load T, clear E");
    send(V_TAG, 0, 0, 0, "R3 tag after load");
    send(V_WAIT, 0, 0, 2, "R6 R7 wait read with E clear not blocked");
    send(V_WAIT, 1, 32'h11, 0, "R9 push");
    send(V_WAIT, 1, 32'h22, 0, "R9 push");
    send(V_WAIT, 1, 32'h33, 0, "R9 push");
    send(V_TAG, 1, ctlWord(0, 0, 1), 0, "R3 E set flushes count");
    send(V_TAG, 0, 0, 0, "R3 count cleared");
    send(V_TAG, 1, ctlWord(0, 1, 0), 0, "R3 load F with empty queue");
    send(V_WAIT, 1, 32'h44, 3, "R8 write blocked by loaded F");
    send(V_POLL, 0, 0, 1, "R6 R10 read clears F and wakes");
    send(V_WAIT, 1, 32'h55, 3, "R8 write proceeds after F clear");
    send(V_RAW, 0, 0, 0, "R4 head after flush");
    idle(2);

    for (int i = 0; i < 600; i++) begin
      logic [1:0] v = 2'($urandom_range(0, 3));
      bit w = 1'($urandom_range(0, 1));
      logic [DATA_W-1:0] d = $urandom;
      if (v == V_TAG && w) d = ctlWord(1'($urandom), 1'($urandom_range(0, 5) == 0), 1'($urandom_range(0, 7) == 0));
      send(v, w, d, $urandom_range(0, NUM_REQ - 1), "R12 mixed traffic");
      if ($urandom_range(0, 4) == 0) idle(1);
    end
    idle(3);
    check(qData.size() == 0, "R1 all responses seen",
          $sformatf("%0d", qData.size()), "0");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule